// File: doc/BRIEF.md
# Hot-Line SRAM Side-Store Controller

This controller sits next to the tag directory of a set-associative last-level cache whose main data array wears out under repeated writes. Every request that reaches it has already hit in the tag directory, so it arrives as a set, a way, an operation and a full data line. The controller keeps a saturating write counter for every block. When a block's writes climb past a programmable threshold, it moves the block into a small SRAM side-store, which then serves all later reads and writes to that block. The side-store holds no tags. Each set may park at most one block there, and a per-set pointer records which way is parked and in which entry.

There are three operations, encoded on `req_op`: 0 is a read, 1 is a full-line write, and 2 is a fill. A fill tells the controller that the cache evicted the block at (set, way) and put a new line in its place. Main-array traffic leaves the block as read and write commands. The array answers reads combinationally on `arr_rdata`. Moving a parked line back into the main array takes a fixed number of busy cycles. Looking for a victim among full entries takes a further fixed number. While `busy` is high, requests are ignored.

Top module: `hotline_ctrl`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low, no block is parked, all entries are free and every write counter is zero.
- R2: Each block has an 8-bit write counter. Every accepted write adds one to it, whether the block is parked or in the main array, and the counter stops at 255 and never wraps. A fill clears it to zero.
- R3: A write to a block that is not parked makes it a candidate only when its updated count is strictly greater than the threshold. The threshold is `lam` clamped to the range 2..4: values below 2 act as 2 and values above 4 act as 4. Changing `lam` never changes the data that reads return.
- R4: A candidate in a set with no parked block goes to the lowest-numbered free entry when one exists. Its write data lands in the side-store and no array write is issued for it.
- R5: A candidate whose set already has a parked block replaces that block only when the candidate's count is strictly greater. The old line is then written back to the array at its own set and way. On a tie or lower count, the write goes to the array.
- R6: Reads, writes and fills to a parked block are served from its entry and issue no array command.
- R7: When all entries are full and the candidate's set has no parked block, the victim is the entry whose owner block has the lowest count, with the lowest entry index winning ties. It is displaced and written back only when its count is strictly lower than the candidate's. Otherwise the write goes to the array.
- R8: A fill to a parked block writes the new line into the same entry, and the block stays parked. A fill to any other block is written to the array.
- R9: A victim search holds `busy` high for VIC_LAT cycles and a write-back for MOVE_CYC cycles, the two adding when both happen. The write-back's array write is issued in the last busy cycle. Requests presented while `busy` is high are ignored.
- R10: `rsp_valid` rises exactly one cycle after each accepted read. `rsp_data` carries the line most recently written or filled for that block.
- R11: At most one block per set is parked at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| lam | input | 3 | promotion threshold, clamped to 2..4 |
| req_valid | input | 1 | request present |
| req_op | input | 2 | 0 read, 1 write, 2 fill after eviction |
| req_set | input | log2(SETS) | set of the block |
| req_way | input | log2(WAYS) | way of the block |
| req_data | input | LINE_W | write or fill line |
| busy | output | 1 | a search or write-back is in progress; requests ignored |
| arr_re | output | 1 | main-array read command |
| arr_we | output | 1 | main-array write command |
| arr_set | output | log2(SETS) | array command set |
| arr_way | output | log2(WAYS) | array command way |
| arr_wdata | output | LINE_W | array write line |
| arr_rdata | input | LINE_W | array read line, same cycle |
| rsp_valid | output | 1 | read response valid |
| rsp_data | output | LINE_W | read response line |

## Verification
Array commands for an accepted request appear in the same cycle as the request. A read response appears one cycle later. A write-back appears VIC_LAT+MOVE_CYC or MOVE_CYC cycles after the request that caused it, in the last cycle that `busy` is high. The bench drives inputs on the falling edge and samples the combinational outputs a few nanoseconds later, still before the rising edge. It compares them in that same cycle against a behavioural model that keeps its own timer for the busy window. It checks the response one cycle after the read against a golden store of the last line written to each block.

// File: rtl/hotline_ctrl.sv
module hotline_ctrl #(
  parameter int SETS     = 64,
  parameter int WAYS     = 4,
  parameter int LINE_W   = 32,
  parameter int CNT_W    = 8,
  parameter int FRAC     = 16,
  parameter int MOVE_CYC = 2,
  parameter int VIC_LAT  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                lam,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [$clog2(SETS)-1:0]   req_set,
  input  logic [$clog2(WAYS)-1:0]   req_way,
  input  logic [LINE_W-1:0]         req_data,
  output logic                      busy,
  output logic                      arr_re,
  output logic                      arr_we,
  output logic [$clog2(SETS)-1:0]   arr_set,
  output logic [$clog2(WAYS)-1:0]   arr_way,
  output logic [LINE_W-1:0]         arr_wdata,
  input  logic [LINE_W-1:0]         arr_rdata,
  output logic                      rsp_valid,
  output logic [LINE_W-1:0]         rsp_data
);
  localparam int SW  = $clog2(SETS);
  localparam int WW  = $clog2(WAYS);
  localparam int ENT = (SETS / FRAC) > 0 ? SETS / FRAC : 1;
  localparam int EW  = ENT > 1 ? $clog2(ENT) : 1;
  localparam int TW  = $clog2(VIC_LAT + MOVE_CYC + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0]  cnt     [SETS*WAYS];
  logic [SETS-1:0]   res_v;
  logic [WW-1:0]     res_way [SETS];
  logic [EW-1:0]     res_idx [SETS];
  logic [ENT-1:0]    s_v;
  logic [SW-1:0]     s_set   [ENT];
  logic [LINE_W-1:0] s_data  [ENT];

  logic [TW-1:0]     timer;
  logic              cb_pend;
  logic [SW-1:0]     cb_set;
  logic [WW-1:0]     cb_way;
  logic [LINE_W-1:0] cb_data;

  logic              acc, is_rd, is_wr, is_fl;
  logic              hit, other, cand;
  logic              p_same, p_free, vsrch, p_vic, promote, cb_fire, acc_aw;
  logic [EW-1:0]     hidx, slot, fidx, vidx;
  logic              fvld, vfound;
  logic [CNT_W-1:0]  cur, nxt, ocnt, vcnt, lam_e;

  assign busy  = (timer != '0);
  assign acc   = req_valid && !busy;
  assign is_rd = acc && (req_op == 2'd0);
  assign is_wr = acc && (req_op == 2'd1);
  assign is_fl = acc && (req_op == 2'd2);

  assign lam_e = (lam < 3'd2) ? CNT_W'(2) : (lam > 3'd4) ? CNT_W'(4) : CNT_W'(lam);
  assign cur   = cnt[{req_set, req_way}];
  assign nxt   = (cur == CMAX) ? cur : cur + 1'b1;

  assign hit   = res_v[req_set] && (res_way[req_set] == req_way);
  assign other = res_v[req_set] && !hit;
  assign hidx  = res_idx[req_set];
  assign ocnt  = cnt[{req_set, res_way[req_set]}];

  always_comb begin
    fvld   = 1'b0;
    fidx   = '0;
    vfound = 1'b0;
    vidx   = '0;
    vcnt   = '0;
    for (int e = ENT - 1; e >= 0; e--) begin
      if (!s_v[e]) begin
        fvld = 1'b1;
        fidx = EW'(e);
      end
    end
    for (int e = 0; e < ENT; e++) begin
      if (s_v[e] && (!vfound || cnt[{s_set[e], res_way[s_set[e]]}] < vcnt)) begin
        vfound = 1'b1;
        vidx   = EW'(e);
        vcnt   = cnt[{s_set[e], res_way[s_set[e]]}];
      end
    end
  end

  assign cand    = is_wr && !hit && (nxt > lam_e);
  assign p_same  = cand && other && (nxt > ocnt);
  assign p_free  = cand && !other && fvld;
  assign vsrch   = cand && !other && !fvld;
  assign p_vic   = vsrch && (vcnt < nxt);
  assign promote = p_same || p_free || p_vic;
  assign slot    = p_same ? hidx : (p_free ? fidx : vidx);

  assign cb_fire   = cb_pend && (timer == TW'(1));
  assign acc_aw    = (is_wr && !hit && !promote) || (is_fl && !hit);
  assign arr_re    = is_rd && !hit;
  assign arr_we    = acc_aw || cb_fire;
  assign arr_set   = cb_fire ? cb_set  : req_set;
  assign arr_way   = cb_fire ? cb_way  : req_way;
  assign arr_wdata = cb_fire ? cb_data : req_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS*WAYS; i++) cnt[i] <= '0;
      res_v     <= '0;
      s_v       <= '0;
      timer     <= '0;
      cb_pend   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      if (busy) timer <= timer - 1'b1;
      if (cb_fire) cb_pend <= 1'b0;
      rsp_valid <= is_rd;
      if (is_rd) rsp_data <= hit ? s_data[hidx] : arr_rdata;
      if (is_wr) begin
        cnt[{req_set, req_way}] <= nxt;
        if (hit) s_data[hidx] <= req_data;
      end
      if (is_fl) begin
        cnt[{req_set, req_way}] <= '0;
        if (hit) s_data[hidx] <= req_data;
      end
      if (p_vic) res_v[s_set[vidx]] <= 1'b0;
      if (promote) begin
        s_v[slot]        <= 1'b1;
        s_set[slot]      <= req_set;
        s_data[slot]     <= req_data;
        res_v[req_set]   <= 1'b1;
        res_way[req_set] <= req_way;
        res_idx[req_set] <= slot;
      end
      if (p_same) begin
        cb_pend <= 1'b1;
        cb_set  <= req_set;
        cb_way  <= res_way[req_set];
        cb_data <= s_data[hidx];
      end else if (p_vic) begin
        cb_pend <= 1'b1;
        cb_set  <= s_set[vidx];
        cb_way  <= res_way[s_set[vidx]];
        cb_data <= s_data[vidx];
      end
      if (vsrch || p_same)
        timer <= (vsrch ? TW'(VIC_LAT) : TW'(0)) + ((p_same || p_vic) ? TW'(MOVE_CYC) : TW'(0));
    end
  end
endmodule

module hotline_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       busy,
  input logic       hit,
  input logic       arr_re,
  input logic       arr_we,
  input logic       rsp_valid
);
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_re);
  a_r6_parked_no_array: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && hit) |-> (!arr_re && !arr_we));
  a_r10_rsp_has_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !busy && req_op == 2'd0));
  a_r10_read_gets_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == 2'd0) |=> rsp_valid);
  a_r9_one_array_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_re && arr_we));
endmodule

bind hotline_ctrl hotline_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .hit(hit), .arr_re(arr_re), .arr_we(arr_we), .rsp_valid(rsp_valid)
);

// File: tb/tb_hotline_ctrl.sv
module tb_hotline_ctrl;
  localparam int SETS = 64, WAYS = 4, LW = 32, FRAC = 16, MOVE = 2, VLAT = 4;
  localparam int ENT = SETS / FRAC;

  logic clk = 0, rst_n = 0;
  logic [2:0] lam = 3'd2;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [5:0] req_set = 0;
  logic [1:0] req_way = 0;
  logic [LW-1:0] req_data = 0;
  logic busy, arr_re, arr_we, rsp_valid;
  logic [5:0] arr_set;
  logic [1:0] arr_way;
  logic [LW-1:0] arr_wdata, arr_rdata, rsp_data;

  always #10 clk = ~clk;

  hotline_ctrl #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LW), .CNT_W(8), .FRAC(FRAC),
                 .MOVE_CYC(MOVE), .VIC_LAT(VLAT)) dut (.*);

  logic [LW-1:0] mem [SETS*WAYS];
  initial for (int i = 0; i < SETS*WAYS; i++) mem[i] = '0;
  assign arr_rdata = mem[arr_set*WAYS + arr_way];
  always @(posedge clk) if (arr_we) mem[arr_set*WAYS + arr_way] <= arr_wdata;

  int errors = 0, checks = 0;
  int m_cnt [SETS*WAYS];
  bit m_rv [SETS];
  int m_rway [SETS], m_ridx [SETS];
  bit m_sv [ENT];
  int m_sset [ENT];
  logic [LW-1:0] m_sdata [ENT];
  logic [LW-1:0] gold [SETS*WAYS];
  int m_timer = 0;
  bit m_cbp = 0;
  int m_cbs, m_cbw;
  logic [LW-1:0] m_cbd;
  bit x_rv = 0;
  logic [LW-1:0] x_rd;
  string ph = "R1";
  int we_seen;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int op, input int s, input int w, input logic [LW-1:0] d);
    int lamv, bi, nxt, ocnt, fi, vi, vc, slot;
    bit acc, hit, other, e_re, e_we, prom, same, pvic, vs;
    int e_set, e_way;
    logic [LW-1:0] e_wd;
    string tg;
    @(negedge clk);
    req_valid = v; req_op = 2'(op); req_set = 6'(s); req_way = 2'(w); req_data = d;
    #5;
    lamv = lam < 2 ? 2 : (lam > 4 ? 4 : int'(lam));
    acc = v && (m_timer == 0);
    bi = s*WAYS + w;
    hit = m_rv[s] && m_rway[s] == w;
    other = m_rv[s] && !hit;
    e_re = 0; e_we = 0; e_set = s; e_way = w; e_wd = d; prom = 0; same = 0; pvic = 0; vs = 0;
    tg = {ph, "/R9"};
    if (m_cbp && m_timer == 1) begin
      e_we = 1; e_set = m_cbs; e_way = m_cbw; e_wd = m_cbd;
      tg = {ph, "/R9-R5R7"};
    end
    nxt = 0; fi = -1; vi = -1; vc = 0; slot = 0; ocnt = 0;
    if (acc && op == 0) begin
      e_re = !hit; tg = hit ? {ph, "/R6"} : {ph, "/R10"};
    end
    if (acc && op == 1) begin
      nxt = m_cnt[bi] == 255 ? 255 : m_cnt[bi] + 1;
      tg = hit ? {ph, "/R6"} : {ph, "/R3"};
      if (!hit && nxt > lamv) begin
        if (other) begin
          ocnt = m_cnt[s*WAYS + m_rway[s]];
          same = nxt > ocnt; tg = {ph, "/R5"};
        end else begin
          for (int e = ENT - 1; e >= 0; e--) if (!m_sv[e]) fi = e;
          if (fi < 0) begin
            vs = 1; tg = {ph, "/R7"};
            for (int e = 0; e < ENT; e++) begin
              int c;
              c = m_cnt[m_sset[e]*WAYS + m_rway[m_sset[e]]];
              if (vi < 0 || c < vc) begin vi = e; vc = c; end
            end
            pvic = vc < nxt;
          end else tg = {ph, "/R4"};
        end
        prom = same || pvic || (fi >= 0);
      end
      if (!hit && !prom) e_we = 1;
    end
    if (acc && op == 2) begin
      tg = {ph, "/R8"};
      if (!hit) e_we = 1;
    end
    chk(busy == (m_timer != 0), {tg, " busy"}, busy, m_timer != 0);
    chk(arr_re == e_re, {tg, " arr_re"}, arr_re, e_re);
    chk(arr_we == e_we, {tg, " arr_we"}, arr_we, e_we);
    if (e_we || e_re) chk(arr_set == e_set && arr_way == e_way, {tg, " addr"}, {arr_set, arr_way}, {6'(e_set), 2'(e_way)});
    if (e_we) chk(arr_wdata == e_wd, {tg, " wdata"}, arr_wdata, e_wd);
    chk(rsp_valid == x_rv, {ph, "/R10 rsp_valid"}, rsp_valid, x_rv);
    if (x_rv) chk(rsp_data == x_rd, {ph, "/R10 rsp_data"}, rsp_data, x_rd);
    if (arr_we) we_seen++;
    // commit
    if (m_timer != 0) m_timer--;
    if (m_cbp && m_timer == 0) m_cbp = 0;
    x_rv = acc && op == 0;
    if (x_rv) x_rd = gold[bi];
    if (acc && op == 1) begin
      m_cnt[bi] = nxt; gold[bi] = d;
      if (hit) m_sdata[m_ridx[s]] = d;
      if (prom) begin
        if (same) begin
          slot = m_ridx[s]; m_cbs = s; m_cbw = m_rway[s]; m_cbd = m_sdata[slot]; m_cbp = 1;
        end else if (pvic) begin
          slot = vi; m_cbs = m_sset[vi]; m_cbw = m_rway[m_sset[vi]]; m_cbd = m_sdata[vi]; m_cbp = 1;
          m_rv[m_sset[vi]] = 0;
        end else slot = fi;
        m_sv[slot] = 1; m_sset[slot] = s; m_sdata[slot] = d;
        m_rv[s] = 1; m_rway[s] = w; m_ridx[s] = slot;
      end
      if (vs || same) m_timer = (vs ? VLAT : 0) + ((same || pvic) ? MOVE : 0);
    end
    if (acc && op == 2) begin
      m_cnt[bi] = 0; gold[bi] = d;
      if (hit) m_sdata[m_ridx[s]] = d;
    end
    @(posedge clk);
  endtask

  task automatic wr(input int s, input int w, input logic [LW-1:0] d);
    while (m_timer != 0) cyc(0, 0, 0, 0, 0);
    cyc(1, 1, s, w, d);
  endtask
  task automatic rd(input int s, input int w);
    while (m_timer != 0) cyc(0, 0, 0, 0, 0);
    cyc(1, 0, s, w, 0);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS*WAYS; i++) begin m_cnt[i] = 0; gold[i] = 0; end
    for (int i = 0; i < SETS; i++) m_rv[i] = 0;
    for (int i = 0; i < ENT; i++) m_sv[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    ph = "R1";
    cyc(0, 0, 0, 0, 0);
    rd(1, 0);
    cyc(0, 0, 0, 0, 0);
    ph = "R4";
    wr(1, 0, 32'hA1); wr(1, 0, 32'hA2);
    we_seen = 0; wr(1, 0, 32'hA3);
    chk(we_seen == 0, "R4 promoted write kept off array", we_seen, 0);
    ph = "R6"; rd(1, 0); wr(1, 0, 32'hA4); rd(1, 0);
    ph = "R5";
    wr(1, 1, 32'hB1); wr(1, 1, 32'hB2); wr(1, 1, 32'hB3); wr(1, 1, 32'hB4);
    wr(1, 1, 32'hB5); wr(1, 1, 32'hB6);
    rd(1, 0); rd(1, 1);
    ph = "R7";
    for (int s = 2; s <= 5; s++) for (int k = 0; k < 3; k++) wr(s, 2, 32'h100*s + k);
    for (int k = 0; k < 5; k++) wr(6, 3, 32'h600 + k);
    rd(6, 3); rd(2, 2); rd(3, 2);
    ph = "R8";
    cyc(1, 2, 6, 3, 32'hF6); rd(6, 3);
    cyc(1, 2, 7, 0, 32'hF7); rd(7, 0);
    ph = "R9";
    for (int k = 0; k < 6; k++) cyc(1, 1, 9, k % 4, 32'h900 + k);
    rd(9, 0); rd(9, 1);
    ph = "R3";
    lam = 3'd7;
    for (int k = 0; k < 5; k++) wr(10, 1, 32'hA00 + k);
    lam = 3'd0;
    for (int k = 0; k < 3; k++) wr(11, 1, 32'hB00 + k);
    ph = "R2";
    for (int k = 0; k < 300; k++) wr(12, 0, 32'hC00 + k);
    for (int k = 0; k < 300; k++) wr(12, 1, 32'hD00 + k);
    rd(12, 0); rd(12, 1);
    ph = "R11";
    for (int n = 0; n < 4000; n++) begin
      int op;
      if (n % 97 == 0) lam = 3'($urandom_range(0, 7));
      op = $urandom_range(0, 9);
      op = op < 3 ? 0 : (op < 9 ? 1 : 2);
      cyc($urandom_range(0, 4) != 0, op, $urandom_range(0, 7), $urandom_range(0, 3), $urandom);
    end
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) rd(s, w);
    cyc(0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule